// File: doc/BRIEF.md
# Virtual-8086 Interrupt Entry Sequencer

This control block performs the privileged entry steps when an interrupt or exception is taken while the core runs virtual-8086 code. The caller pulses `start` together with the vector's gate descriptor fields (gate type, target code-segment selector, conforming bit, target privilege level), the current register values and the level-0 stack pointer. The block checks the target in the first busy cycle. A failed check raises a general-protection fault and nothing else changes. A task gate raises a task-switch request for a separate unit. A legal trap or interrupt gate starts the entry sequence.

For a legal entry the block first signals the switch to 32-bit protected mode at privilege level 0. It then issues nine 32-bit stack writes that record the interrupted context. After the writes it strobes the clearing of the four data segment registers and the flag update, and finally pulses the handler start. The caller follows the `busy`/`done` handshake. Descriptor fetch, the memory system and the task switch itself are outside the block.

Top module: `v86e_top`

## Requirements
- R1: A gate type of 4'h5 (task gate) gives, in the cycle after `start` is sampled, a one-cycle `task_req` with `done`, and no stack write, mode switch, fault or handler start.
- R2: A trap gate (4'hF) or interrupt gate (4'hE) whose target is conforming gives, in the cycle after `start`, a one-cycle `gp_fault` with `done` and `gp_err` equal to the target selector, and no stack write or mode switch.
- R3: A trap or interrupt gate whose target privilege level is not 0 faults in the same way as R2.
- R4: Any gate type other than 4'h5, 4'hE or 4'hF faults in the same way as R2.
- R5: For a legal entry, `mode_sw` pulses in the cycle after `start` is sampled, one cycle before the first stack write.
- R6: A legal entry issues exactly nine consecutive writes. Write k (k = 0..8) goes to address `stk0_ptr - 4*(k+1)` and carries GS, FS, DS, ES, SS, ESP, EFLAGS, CS, EIP in that order. Segment values are zero-extended to 32 bits.
- R7: The EFLAGS word written to the stack is the value captured at `start`, before any bit is cleared, so the VM bit (bit 17) is recorded as set.
- R8: In the cycle after the last write, `seg_clr` pulses, and `esp_new` equals `stk0_ptr - 36`.
- R9: In that same cycle `flags_wr` pulses. `flags_new` is the captured EFLAGS with VM (bit 17), RF (bit 16), NT (bit 14) and TF (bit 8) cleared. IF (bit 9) is also cleared for an interrupt gate and kept for a trap gate.
- R10: `hdl_start` and `done` pulse one cycle after `seg_clr`/`flags_wr`. `busy` is low after reset and high from the cycle after `start` through the `done` cycle, then low again.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the writes in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Entry request, accepted only when idle |
| gate_type | input | 4 | Gate descriptor type code |
| tgt_sel | input | 16 | Target code-segment selector |
| tgt_conf | input | 1 | Target segment is conforming |
| tgt_dpl | input | 2 | Target segment privilege level |
| cur_eip | input | 32 | Instruction pointer to save |
| cur_cs | input | 16 | Code segment to save |
| cur_eflags | input | 32 | Flags to save |
| cur_esp | input | 32 | Stack pointer to save |
| cur_ss | input | 16 | Stack segment to save |
| cur_ds | input | 16 | Data segment to save |
| cur_es | input | 16 | Extra segment to save |
| cur_fs | input | 16 | F segment to save |
| cur_gs | input | 16 | G segment to save |
| stk0_ptr | input | 32 | Level-0 stack pointer before the pushes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of any outcome |
| mode_sw | output | 1 | Switch to 32-bit protected mode, level 0 |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| seg_clr | output | 1 | Zero DS, ES, FS and GS |
| flags_wr | output | 1 | Load `flags_new` into EFLAGS |
| flags_new | output | 32 | Updated flags value |
| esp_new | output | 32 | Stack pointer after the pushes |
| hdl_start | output | 1 | Begin handler execution |
| gp_fault | output | 1 | General-protection fault |
| gp_err | output | 16 | Fault error code (target selector) |
| task_req | output | 1 | Task-switch request |

## Verification
The assertions watch, on every cycle, the ordering rules: the mode switch comes right before the first write, write addresses step down by one word, a fault occurs without any write or mode switch, the handler start follows the segment and flag update, at most one outcome fires at a time, and `done` returns the block to idle. Whether each written word holds the right register in the right slot, that the saved flags still carry VM, that IF is treated differently for the two gate kinds, and that a `start` during a sequence leaves the writes unchanged can only be shown by the bench's scenarios with known register values.

// File: rtl/v86e_pkg.sv
package v86e_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CHK, ST_PUSH, ST_UPD, ST_GO} v86e_st_e;
  typedef enum logic [1:0] {GC_ENTER, GC_TASK, GC_FAULT} v86e_cls_e;

  localparam logic [3:0] GT_TASK   = 4'h5;
  localparam logic [3:0] GT_INT32  = 4'hE;
  localparam logic [3:0] GT_TRAP32 = 4'hF;

  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_NT = 14;
  localparam int FL_RF = 16;
  localparam int FL_VM = 17;

  localparam int NPUSH = 9;
endpackage

// File: rtl/v86e_gate_chk.sv
module v86e_gate_chk
  import v86e_pkg::*;
#(
  parameter int GTW = 4,
  parameter int PLW = 2
) (
  input  logic [GTW-1:0] gate_type,
  input  logic           tgt_conf,
  input  logic [PLW-1:0] tgt_dpl,
  output v86e_cls_e      cls,
  output logic           is_int
);
  logic is_task, is_trap_int, seg_ok;

  always_comb begin
    is_task     = (gate_type == GTW'(GT_TASK));
    is_int      = (gate_type == GTW'(GT_INT32));
    is_trap_int = is_int || (gate_type == GTW'(GT_TRAP32));
    seg_ok      = !tgt_conf && (tgt_dpl == '0);
    if (is_task)                   cls = GC_TASK;
    else if (is_trap_int && seg_ok) cls = GC_ENTER;
    else                           cls = GC_FAULT;
  end
endmodule

// File: rtl/v86e_push_mux.sv
module v86e_push_mux
  import v86e_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SELW = 16,
  parameter int IW   = 4
) (
  input  logic [IW-1:0]   idx,
  input  logic [SELW-1:0] gs,
  input  logic [SELW-1:0] fs,
  input  logic [SELW-1:0] ds,
  input  logic [SELW-1:0] es,
  input  logic [SELW-1:0] ss,
  input  logic [DW-1:0]   esp,
  input  logic [DW-1:0]   eflags,
  input  logic [SELW-1:0] cs,
  input  logic [DW-1:0]   eip,
  output logic [DW-1:0]   word
);
  localparam int NSEG = 5;
  logic [SELW-1:0] segs  [NSEG];
  logic [DW-1:0]   words [NPUSH];

  assign segs[0] = gs;
  assign segs[1] = fs;
  assign segs[2] = ds;
  assign segs[3] = es;
  assign segs[4] = ss;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign words[g] = {{(DW-SELW){1'b0}}, segs[g]};
  end
  assign words[5] = esp;
  assign words[6] = eflags;
  assign words[7] = {{(DW-SELW){1'b0}}, cs};
  assign words[8] = eip;

  always_comb begin
    word = '0;
    for (int k = 0; k < NPUSH; k++)
      if (idx == IW'(k)) word = words[k];
  end
endmodule

// File: rtl/v86e_top.sv
module v86e_top
  import v86e_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SELW = 16,
  parameter int PLW  = 2,
  parameter int GTW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [GTW-1:0]  gate_type,
  input  logic [SELW-1:0] tgt_sel,
  input  logic            tgt_conf,
  input  logic [PLW-1:0]  tgt_dpl,
  input  logic [DW-1:0]   cur_eip,
  input  logic [SELW-1:0] cur_cs,
  input  logic [DW-1:0]   cur_eflags,
  input  logic [DW-1:0]   cur_esp,
  input  logic [SELW-1:0] cur_ss,
  input  logic [SELW-1:0] cur_ds,
  input  logic [SELW-1:0] cur_es,
  input  logic [SELW-1:0] cur_fs,
  input  logic [SELW-1:0] cur_gs,
  input  logic [AW-1:0]   stk0_ptr,
  output logic            busy,
  output logic            done,
  output logic            mode_sw,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            seg_clr,
  output logic            flags_wr,
  output logic [DW-1:0]   flags_new,
  output logic [AW-1:0]   esp_new,
  output logic            hdl_start,
  output logic            gp_fault,
  output logic [SELW-1:0] gp_err,
  output logic            task_req
);
  localparam int IW = $clog2(NPUSH + 1);
  localparam logic [AW-1:0] WB = AW'(DW / 8);

  v86e_st_e st_q, st_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  logic            cap_en, step_en;

  logic [GTW-1:0]  gt_q;
  logic [SELW-1:0] sel_q, cs_q, ss_q, ds_q, es_q, fs_q, gs_q;
  logic            conf_q;
  logic [PLW-1:0]  dpl_q;
  logic [DW-1:0]   eip_q, fl_q, esp_q;

  v86e_cls_e cls;
  logic      is_int;
  logic [DW-1:0] clr_mask;

  v86e_gate_chk #(.GTW(GTW), .PLW(PLW)) u_gchk (
    .gate_type(gt_q), .tgt_conf(conf_q), .tgt_dpl(dpl_q),
    .cls(cls), .is_int(is_int)
  );

  v86e_push_mux #(.DW(DW), .SELW(SELW), .IW(IW)) u_mux (
    .idx(idx_q), .gs(gs_q), .fs(fs_q), .ds(ds_q), .es(es_q), .ss(ss_q),
    .esp(esp_q), .eflags(fl_q), .cs(cs_q), .eip(eip_q), .word(wr_data)
  );

  // next state
  always_comb begin
    cap_en  = (st_q == ST_IDLE) && start;
    step_en = (st_q == ST_PUSH);
    st_d    = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_CHK;
      ST_CHK:  st_d = (cls == GC_ENTER) ? ST_PUSH : ST_IDLE;
      ST_PUSH: if (idx_q == IW'(NPUSH - 1)) st_d = ST_UPD;
      ST_UPD:  st_d = ST_GO;
      ST_GO:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    idx_d = cap_en ? '0 : (step_en ? idx_q + IW'(1) : idx_q);
    ptr_d = cap_en ? stk0_ptr : (step_en ? ptr_q - WB : ptr_q);
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      ptr_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en || step_en) begin
        idx_q <= idx_d;
        ptr_q <= ptr_d;
      end
    end
  end

  // context capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gt_q <= '0; sel_q <= '0; conf_q <= 1'b0; dpl_q <= '0;
      eip_q <= '0; cs_q <= '0; fl_q <= '0; esp_q <= '0;
      ss_q <= '0; ds_q <= '0; es_q <= '0; fs_q <= '0; gs_q <= '0;
    end else if (cap_en) begin
      gt_q <= gate_type; sel_q <= tgt_sel; conf_q <= tgt_conf; dpl_q <= tgt_dpl;
      eip_q <= cur_eip; cs_q <= cur_cs; fl_q <= cur_eflags; esp_q <= cur_esp;
      ss_q <= cur_ss; ds_q <= cur_ds; es_q <= cur_es; fs_q <= cur_fs; gs_q <= cur_gs;
    end
  end

  // outputs
  always_comb begin
    clr_mask = '0;
    clr_mask[FL_VM] = 1'b1;
    clr_mask[FL_RF] = 1'b1;
    clr_mask[FL_NT] = 1'b1;
    clr_mask[FL_TF] = 1'b1;
    clr_mask[FL_IF] = is_int;

    busy      = (st_q != ST_IDLE);
    mode_sw   = (st_q == ST_CHK) && (cls == GC_ENTER);
    gp_fault  = (st_q == ST_CHK) && (cls == GC_FAULT);
    task_req  = (st_q == ST_CHK) && (cls == GC_TASK);
    done      = ((st_q == ST_CHK) && (cls != GC_ENTER)) || (st_q == ST_GO);
    gp_err    = sel_q;
    wr_en     = (st_q == ST_PUSH);
    wr_addr   = ptr_q - WB;
    seg_clr   = (st_q == ST_UPD);
    flags_wr  = (st_q == ST_UPD);
    flags_new = fl_q & ~clr_mask;
    esp_new   = ptr_q;
    hdl_start = (st_q == ST_GO);
  end
endmodule

// File: rtl/v86e_chk.sv
module v86e_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SELW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mode_sw,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          seg_clr,
  input logic          flags_wr,
  input logic [DW-1:0] flags_new,
  input logic          hdl_start,
  input logic          gp_fault,
  input logic          task_req
);
  localparam logic [AW-1:0] WB = AW'(DW / 8);

  AST_MODE_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(mode_sw)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - WB)); // R6
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (!wr_en && !mode_sw && !seg_clr && done)); // R2
  AST_TASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    task_req |-> (!wr_en && !mode_sw && done)); // R1
  AST_FLAGS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flags_wr |-> (flags_new[17] == 1'b0 && flags_new[16] == 1'b0 &&
                  flags_new[14] == 1'b0 && flags_new[8] == 1'b0)); // R9
  AST_GO_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_start |-> ($past(seg_clr) && $past(flags_wr))); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdl_start, gp_fault, task_req})); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
endmodule

bind v86e_top v86e_chk #(.AW(AW), .DW(DW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_sw(mode_sw),
  .wr_en(wr_en), .wr_addr(wr_addr), .seg_clr(seg_clr), .flags_wr(flags_wr),
  .flags_new(flags_new), .hdl_start(hdl_start), .gp_fault(gp_fault),
  .task_req(task_req)
);

// File: tb/v86e_top_bench.sv
module v86e_top_bench;
  logic clk, rst_n, start;
  logic [3:0]  gate_type;
  logic [15:0] tgt_sel, cur_cs, cur_ss, cur_ds, cur_es, cur_fs, cur_gs;
  logic        tgt_conf;
  logic [1:0]  tgt_dpl;
  logic [31:0] cur_eip, cur_eflags, cur_esp, stk0_ptr;
  logic busy, done, mode_sw, wr_en, seg_clr, flags_wr, hdl_start, gp_fault, task_req;
  logic [31:0] wr_addr, wr_data, flags_new, esp_new;
  logic [15:0] gp_err;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q [$];

  v86e_top u_v86e_top (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected write", wr_addr, 32'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(wr_addr == e[63:32], "R6 write address", wr_addr, e[63:32]);
        chk(wr_data == e[31:0], "R6/R7 write data", wr_data, e[31:0]);
      end
    end
  end

  task automatic set_ctx(input logic [3:0] gt, input bit conf, input logic [1:0] dpl, input logic [31:0] seed);
    gate_type = gt; tgt_conf = conf; tgt_dpl = dpl;
    tgt_sel = 16'h0010 ^ seed[15:0];
    cur_eip = 32'h1000_0000 + seed; cur_cs = 16'hF000 ^ seed[15:0];
    cur_eflags = 32'h0003_7F02;
    cur_esp = 32'h0000_FFF0 - seed; cur_ss = 16'h2000 + seed[15:0];
    cur_ds = 16'h3000 + seed[15:0]; cur_es = 16'h4000 + seed[15:0];
    cur_fs = 16'h5000 + seed[15:0]; cur_gs = 16'h6000 + seed[15:0];
    stk0_ptr = 32'h0008_0000 - (seed << 4);
  endtask

  task automatic run_entry(input logic [3:0] gt, input bit conf, input logic [1:0] dpl,
                           input logic [31:0] seed, input bit poke);
    logic [31:0] words [9];
    logic [31:0] sp, fl, exp_fl;
    bit legal;
    @(negedge clk);
    set_ctx(gt, conf, dpl, seed);
    sp = stk0_ptr; fl = cur_eflags;
    words[0] = {16'h0, cur_gs}; words[1] = {16'h0, cur_fs}; words[2] = {16'h0, cur_ds};
    words[3] = {16'h0, cur_es}; words[4] = {16'h0, cur_ss}; words[5] = cur_esp;
    words[6] = fl; words[7] = {16'h0, cur_cs}; words[8] = cur_eip;
    legal = (gt == 4'hE || gt == 4'hF) && !conf && dpl == 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", {31'h0, busy}, 32'h1);
    if (gt == 4'h5) begin
      chk(task_req && done && !mode_sw && !gp_fault && !wr_en, "R1 task request",
          {27'h0, task_req, done, mode_sw, gp_fault, wr_en}, 32'h18);
    end else if (!legal) begin
      chk(gp_fault && done && !mode_sw && !wr_en && !task_req, "R2/R3/R4 fault outcome",
          {27'h0, gp_fault, done, mode_sw, wr_en, task_req}, 32'h18);
      chk(gp_err == tgt_sel, "R2/R3/R4 error code", {16'h0, gp_err}, {16'h0, tgt_sel});
    end else begin
      chk(mode_sw && !wr_en && !done, "R5 mode switch first", {29'h0, mode_sw, wr_en, done}, 32'h4);
      for (int k = 0; k < 9; k++) exp_q.push_back({sp - 32'(4 * (k + 1)), words[k]});
      for (int k = 0; k < 9; k++) begin
        @(negedge clk);
        chk(wr_en == 1'b1, "R6 write strobe", {31'h0, wr_en}, 32'h1);
        if (poke && k == 2) begin
          set_ctx(4'hE, 1'b0, 2'd0, seed + 32'h55);
          start = 1'b1;
        end else start = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      exp_fl = fl & ~(32'h0003_4100 | ((gt == 4'hE) ? 32'h0000_0200 : 32'h0));
      chk(seg_clr && flags_wr && !wr_en, "R8 clear strobe", {29'h0, seg_clr, flags_wr, wr_en}, 32'h6);
      chk(esp_new == sp - 32'd36, "R8 new stack pointer", esp_new, sp - 32'd36);
      chk(flags_new == exp_fl, "R9 flags update", flags_new, exp_fl);
      @(negedge clk);
      chk(hdl_start && done, "R10 handler start", {30'h0, hdl_start, done}, 32'h3);
      chk(exp_q.size() == 0, "R6 nine writes", exp_q.size(), 32'h0);
    end
    @(negedge clk);
    chk(!busy && !wr_en, poke ? "R11 start while busy ignored" : "R10 idle after done",
        {30'h0, busy, wr_en}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    set_ctx(4'h0, 1'b0, 2'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && !hdl_start && !gp_fault && !task_req, "R10 reset state",
        {26'h0, busy, done, wr_en, hdl_start, gp_fault, task_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run_entry(4'hF, 1'b0, 2'd0, 32'h1, 1'b0);  // trap gate: R5 R6 R7 R8 R9 R10
    run_entry(4'hE, 1'b0, 2'd0, 32'h2, 1'b0);  // interrupt gate clears IF: R9
    run_entry(4'hE, 1'b0, 2'd0, 32'h3, 1'b1);  // start during busy: R11
    run_entry(4'hF, 1'b1, 2'd0, 32'h4, 1'b0);  // conforming: R2
    run_entry(4'hE, 1'b0, 2'd3, 32'h5, 1'b0);  // level 3: R3
    run_entry(4'hF, 1'b0, 2'd1, 32'h6, 1'b0);  // level 1: R3
    run_entry(4'hC, 1'b0, 2'd0, 32'h7, 1'b0);  // bad type: R4
    run_entry(4'h6, 1'b0, 2'd0, 32'h8, 1'b0);  // bad type: R4
    run_entry(4'h5, 1'b1, 2'd3, 32'h9, 1'b0);  // task gate: R1
    run_entry(4'hF, 1'b0, 2'd0, 32'hA, 1'b0);  // entry after task: R6
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule